// File: doc/BRIEF.md
# Capture / Compare / Pulse-Width Unit

A companion peripheral for a free-running 16-bit timer, built around one 16-bit data register. Depending on a 4-bit mode code held in a control byte, the data register records the timer value when the external pin changes (input capture), is compared against the timer to drive the pin or raise events (output compare), or holds a 10-bit duty value for a pulse-width output measured against the timer's low byte extended by a 2-bit fine count.

Software writes the control byte and the two data bytes through a simple strobe-per-register write port and reads both back. Capture events and compare matches set a sticky interrupt flag, which software clears with a dedicated strobe. A special-event compare mode additionally emits one-cycle pulses that restart the timer and start a converter. Writing mode 0000 returns the unit to its idle state. All outputs are registered and change on the clock edge after the input condition that causes them.

Top module: `ccp_unit`

## Requirements
- R1: After reset the control readback, the data readback, `pin_out`, `pin_drive`, `irq_flag`, `tmr_rst_pulse` and `adc_start_pulse` are all zero.
- R2: A control write stores `wr_data[5:0]`; control readback bits 7 and 6 always read zero. `wr_lo` and `wr_hi` load data register bits 7:0 and 15:8 respectively.
- R3: Mode codes 0000, 0001 and 0011 disable the unit: the pin is not driven, `pin_out` is 0, pin edges cause no capture and timer equality causes no match.
- R4: Mode 0101 copies `timer_val` into the data register on each rising edge of `pin_in` (0 then 1 on successive clocks); mode 0100 does so on each falling edge; the other edge is ignored. Each capture sets the flag.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge, counting from entry into the mode.
- R6: The prescale edge count restarts from zero whenever the mode code changes, including a switch between the two prescaled modes.
- R7: On entry to mode 1000 the pin is driven low and a match drives it high; on entry to mode 1001 it is driven high and a match drives it low; mode 0010 drives the pin low on entry and inverts it on each match.
- R8: Modes 1010 and 1011 leave the pin undriven and set only the flag on a match; mode 1011 also raises `tmr_rst_pulse` and `adc_start_pulse` for exactly one clock per match.
- R9: A match occurs once when `timer_val` becomes equal to the data register, not on every cycle the equality persists; a new match needs the equality to end and return.
- R10: The interrupt flag stays set until `flag_clr` is asserted; a capture or match in the same cycle as `flag_clr` leaves the flag set.
- R11: Modes 11xx produce a pulse-width output: with count = {`timer_val[7:0]`, `tmr_fine`} and duty = {data bits 7:0, control bits 5:4}, `pin_out` is 1 while count < duty and 0 otherwise; duty 0 keeps the pin low.
- R12: The duty value takes effect only at count 0; a data or control write in the middle of a period does not change the output until the next count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_val | input | 16 | Free-running timer value |
| tmr_fine | input | 2 | Fine count extending the timer low byte in pulse-width mode |
| pin_in | input | 1 | Synchronized external pin level |
| wr_ctrl | input | 1 | Write strobe for the control byte |
| wr_lo | input | 1 | Write strobe for data register bits 7:0 |
| wr_hi | input | 1 | Write strobe for data register bits 15:8 |
| wr_data | input | 8 | Write data byte |
| flag_clr | input | 1 | Clears the interrupt flag |
| ctrl_rd | output | 8 | Control byte readback |
| data_rd | output | 16 | Data register readback |
| pin_out | output | 1 | Pin level driven by the unit |
| pin_drive | output | 1 | 1 when the unit owns the pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| tmr_rst_pulse | output | 1 | One-cycle timer restart request |
| adc_start_pulse | output | 1 | One-cycle converter start request |

## Verification
The hardest situation to reach is a prescale counter that has been left partway through its count when the mode changes, because nothing at the ports shows the count. The bench feeds two rising edges in divide-by-4 mode, switches to divide-by-16 and back, and then shows that three further edges capture nothing while the fourth does; a counter that had kept its value would capture on the second. The mid-period duty write is reached in a similar way: the duty is rewritten while the count sits inside a period, and the old threshold is checked before the new one is checked after the next count 0.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    localparam int DATA_W_DEF = 16;
    localparam int PS_W_DEF   = 4;

    typedef enum logic [1:0] {
        CAP_FALL   = 2'd0,
        CAP_RISE1  = 2'd1,
        CAP_RISE4  = 2'd2,
        CAP_RISE16 = 2'd3
    } cap_kind_e;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_TOGGLE  = 3'd1,
        ACT_SET     = 3'd2,
        ACT_CLEAR   = 3'd3,
        ACT_EVENT   = 3'd4,
        ACT_SPECIAL = 3'd5
    } cmp_act_e;

    typedef struct packed {
        logic      cap_en;
        cap_kind_e cap_kind;
        logic      cmp_en;
        cmp_act_e  cmp_act;
        logic      cmp_init;
        logic      pwm_en;
        logic      drives_pin;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [3:0] m);
        mode_dec_t d;
        d = '0;
        d.cap_kind = CAP_FALL;
        d.cmp_act  = ACT_NONE;
        casez (m)
            4'b0010: begin d.cmp_en = 1'b1; d.cmp_act = ACT_TOGGLE; d.drives_pin = 1'b1; end
            4'b0100: begin d.cap_en = 1'b1; d.cap_kind = CAP_FALL;   end
            4'b0101: begin d.cap_en = 1'b1; d.cap_kind = CAP_RISE1;  end
            4'b0110: begin d.cap_en = 1'b1; d.cap_kind = CAP_RISE4;  end
            4'b0111: begin d.cap_en = 1'b1; d.cap_kind = CAP_RISE16; end
            4'b1000: begin d.cmp_en = 1'b1; d.cmp_act = ACT_SET;   d.cmp_init = 1'b0; d.drives_pin = 1'b1; end
            4'b1001: begin d.cmp_en = 1'b1; d.cmp_act = ACT_CLEAR; d.cmp_init = 1'b1; d.drives_pin = 1'b1; end
            4'b1010: begin d.cmp_en = 1'b1; d.cmp_act = ACT_EVENT;   end
            4'b1011: begin d.cmp_en = 1'b1; d.cmp_act = ACT_SPECIAL; end
            4'b11??: begin d.pwm_en = 1'b1; d.drives_pin = 1'b1; end
            default: d = d;
        endcase
        return d;
    endfunction

    function automatic logic [PS_W_DEF-1:0] prescale_last(input cap_kind_e k);
        logic [PS_W_DEF-1:0] v;
        case (k)
            CAP_RISE4:  v = PS_W_DEF'(3);
            CAP_RISE16: v = PS_W_DEF'(15);
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ccp_regs.sv
module ccp_regs
    import ccp_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [7:0]        wr_data,
    input  logic              cap_load,
    input  logic [DATA_W-1:0] cap_value,
    output logic [7:0]        ctrl_q,
    output logic [DATA_W-1:0] data_q
);
    localparam int HI_W = DATA_W - 8;

    logic [5:0] ctrl_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_bits <= '0;
        end else if (wr_ctrl) begin
            ctrl_bits <= wr_data[5:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            if (cap_load) begin
                data_q <= cap_value;
            end
            if (wr_lo) begin
                data_q[7:0] <= wr_data;
            end
            if (wr_hi) begin
                data_q[DATA_W-1:8] <= wr_data[HI_W-1:0];
            end
        end
    end

    assign ctrl_q = {2'b00, ctrl_bits};

endmodule

// File: rtl/ccp_capture.sv
module ccp_capture
    import ccp_pkg::*;
#(
    parameter int PS_W = PS_W_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_in,
    input  mode_dec_t dec,
    input  logic      mode_chg,
    output logic      cap_evt
);
    logic            pin_d;
    logic            rise;
    logic            fall;
    logic            scaled;
    logic [PS_W-1:0] ps_cnt;
    logic [PS_W-1:0] ps_last;

    always_ff @(posedge clk) begin
        if (rst) pin_d <= 1'b0;
        else     pin_d <= pin_in;
    end

    assign rise    = pin_in & ~pin_d;
    assign fall    = ~pin_in & pin_d;
    assign scaled  = (dec.cap_kind == CAP_RISE4) || (dec.cap_kind == CAP_RISE16);
    assign ps_last = PS_W'(prescale_last(dec.cap_kind));

    always_ff @(posedge clk) begin
        if (rst || !dec.cap_en || mode_chg || !scaled) begin
            ps_cnt <= '0;
        end else if (rise) begin
            ps_cnt <= (ps_cnt == ps_last) ? '0 : ps_cnt + 1'b1;
        end
    end

    always_comb begin
        cap_evt = 1'b0;
        if (dec.cap_en && !mode_chg) begin
            case (dec.cap_kind)
                CAP_FALL:  cap_evt = fall;
                CAP_RISE1: cap_evt = rise;
                default:   cap_evt = rise && (ps_cnt == ps_last);
            endcase
        end
    end

endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
    import ccp_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] timer_val,
    input  logic [DATA_W-1:0] cmp_val,
    input  mode_dec_t         dec,
    input  logic              mode_chg,
    output logic              hit,
    output logic              cmp_pin,
    output logic              tmr_rst_pulse,
    output logic              adc_start_pulse
);
    logic eq;
    logic eq_prev;

    assign eq  = (timer_val == cmp_val);
    assign hit = dec.cmp_en && eq && !eq_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_prev         <= 1'b0;
            cmp_pin         <= 1'b0;
            tmr_rst_pulse   <= 1'b0;
            adc_start_pulse <= 1'b0;
        end else begin
            tmr_rst_pulse   <= 1'b0;
            adc_start_pulse <= 1'b0;
            if (!dec.cmp_en) begin
                eq_prev <= 1'b0;
                cmp_pin <= 1'b0;
            end else begin
                eq_prev <= eq;
                if (mode_chg) begin
                    cmp_pin <= dec.cmp_init;
                end else if (hit) begin
                    case (dec.cmp_act)
                        ACT_TOGGLE: cmp_pin <= ~cmp_pin;
                        ACT_SET:    cmp_pin <= 1'b1;
                        ACT_CLEAR:  cmp_pin <= 1'b0;
                        default:    cmp_pin <= cmp_pin;
                    endcase
                end
                if (hit && dec.cmp_act == ACT_SPECIAL) begin
                    tmr_rst_pulse   <= 1'b1;
                    adc_start_pulse <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
    parameter int HI_W = 8,
    parameter int LO_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwm_en,
    input  logic [HI_W-1:0] cnt_hi,
    input  logic [LO_W-1:0] cnt_lo,
    input  logic [HI_W-1:0] duty_hi,
    input  logic [LO_W-1:0] duty_lo,
    output logic            pwm_pin
);
    localparam int CW = HI_W + LO_W;

    logic [CW-1:0] count;
    logic [CW-1:0] duty_new;
    logic [CW-1:0] duty_lat;

    assign count    = {cnt_hi, cnt_lo};
    assign duty_new = {duty_hi, duty_lo};

    always_ff @(posedge clk) begin
        if (rst || !pwm_en) begin
            duty_lat <= '0;
            pwm_pin  <= 1'b0;
        end else if (count == '0) begin
            duty_lat <= duty_new;
            pwm_pin  <= (duty_new != '0);
        end else begin
            pwm_pin  <= (count < duty_lat);
        end
    end

endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
    import ccp_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int PS_W   = PS_W_DEF,
    parameter int PWM_HI = 8,
    parameter int PWM_LO = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] timer_val,
    input  logic [PWM_LO-1:0] tmr_fine,
    input  logic              pin_in,
    input  logic              wr_ctrl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [7:0]        wr_data,
    input  logic              flag_clr,
    output logic [7:0]        ctrl_rd,
    output logic [DATA_W-1:0] data_rd,
    output logic              pin_out,
    output logic              pin_drive,
    output logic              irq_flag,
    output logic              tmr_rst_pulse,
    output logic              adc_start_pulse
);
    localparam int DUTY_LO_POS = 4;

    logic [3:0] mode_q;
    logic [3:0] mode_prev;
    logic       mode_chg;
    mode_dec_t  dec;
    logic       cap_evt;
    logic       cmp_hit;
    logic       cmp_pin;
    logic       pwm_pin;

    ccp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wr_data   (wr_data),
        .cap_load  (cap_evt),
        .cap_value (timer_val),
        .ctrl_q    (ctrl_rd),
        .data_q    (data_rd)
    );

    assign mode_q = ctrl_rd[3:0];
    assign dec    = decode_mode(mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_prev <= '0;
        else     mode_prev <= mode_q;
    end

    assign mode_chg = (mode_q != mode_prev);

    ccp_capture #(.PS_W(PS_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .dec      (dec),
        .mode_chg (mode_chg),
        .cap_evt  (cap_evt)
    );

    ccp_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk             (clk),
        .rst             (rst),
        .timer_val       (timer_val),
        .cmp_val         (data_rd),
        .dec             (dec),
        .mode_chg        (mode_chg),
        .hit             (cmp_hit),
        .cmp_pin         (cmp_pin),
        .tmr_rst_pulse   (tmr_rst_pulse),
        .adc_start_pulse (adc_start_pulse)
    );

    ccp_pwm #(.HI_W(PWM_HI), .LO_W(PWM_LO)) u_pwm (
        .clk     (clk),
        .rst     (rst),
        .pwm_en  (dec.pwm_en),
        .cnt_hi  (timer_val[PWM_HI-1:0]),
        .cnt_lo  (tmr_fine),
        .duty_hi (data_rd[PWM_HI-1:0]),
        .duty_lo (ctrl_rd[DUTY_LO_POS +: PWM_LO]),
        .pwm_pin (pwm_pin)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_flag <= 1'b0;
        else     irq_flag <= (irq_flag & ~flag_clr) | cap_evt | cmp_hit;
    end

    always_comb begin
        if (dec.pwm_en)          pin_out = pwm_pin;
        else if (dec.drives_pin) pin_out = cmp_pin;
        else                     pin_out = 1'b0;
    end

    assign pin_drive = dec.drives_pin;

endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       flag_clr,
    input logic [7:0] ctrl_rd,
    input logic       pin_out,
    input logic       pin_drive,
    input logic       irq_flag,
    input logic       tmr_rst_pulse,
    input logic       adc_start_pulse
);
    logic off_now;
    logic off_past;

    assign off_now = (ctrl_rd[3:0] == 4'b0000) || (ctrl_rd[3:0] == 4'b0001) ||
                     (ctrl_rd[3:0] == 4'b0011);

    always_ff @(posedge clk) begin
        if (rst) off_past <= 1'b1;
        else     off_past <= off_now;
    end

    // R2
    ctrl_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd[7:6] == 2'b00);

    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (off_now && off_past) |-> (!pin_out && !pin_drive && !tmr_rst_pulse));

    // R8
    special_pair_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_rst_pulse |-> (adc_start_pulse && irq_flag));

    // R8
    special_mode_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_rst_pulse |-> ($past(ctrl_rd[3:0]) == 4'b1011));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_rst_pulse |=> !tmr_rst_pulse);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !flag_clr) |=> irq_flag);

endmodule

bind ccp_unit ccp_unit_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .flag_clr        (flag_clr),
    .ctrl_rd         (ctrl_rd),
    .pin_out         (pin_out),
    .pin_drive       (pin_drive),
    .irq_flag        (irq_flag),
    .tmr_rst_pulse   (tmr_rst_pulse),
    .adc_start_pulse (adc_start_pulse)
);

// File: tb/ccp_unit_bench.sv
`timescale 1ns/1ps
module ccp_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] timer_val = '0;
    logic [1:0]  tmr_fine = '0;
    logic        pin_in = 1'b0;
    logic        wr_ctrl = 1'b0;
    logic        wr_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        flag_clr = 1'b0;
    logic [7:0]  ctrl_rd;
    logic [15:0] data_rd;
    logic        pin_out;
    logic        pin_drive;
    logic        irq_flag;
    logic        tmr_rst_pulse;
    logic        adc_start_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ccp_unit u_ccp_unit (
        .clk             (clk),
        .rst             (rst),
        .timer_val       (timer_val),
        .tmr_fine        (tmr_fine),
        .pin_in          (pin_in),
        .wr_ctrl         (wr_ctrl),
        .wr_lo           (wr_lo),
        .wr_hi           (wr_hi),
        .wr_data         (wr_data),
        .flag_clr        (flag_clr),
        .ctrl_rd         (ctrl_rd),
        .data_rd         (data_rd),
        .pin_out         (pin_out),
        .pin_drive       (pin_drive),
        .irq_flag        (irq_flag),
        .tmr_rst_pulse   (tmr_rst_pulse),
        .adc_start_pulse (adc_start_pulse)
    );

    // PWM vectors: {write data lo, lo value, 10-bit count, expected pin}
    typedef struct packed {
        logic       do_wr;
        logic [7:0] wr_val;
        logic [9:0] cnt;
        logic       exp_pin;
    } pwm_vec_t;

    localparam int NVEC = 15;
    localparam pwm_vec_t PWM_TAB [NVEC] = '{
        '{1'b0, 8'h00, 10'd0,    1'b1},
        '{1'b0, 8'h00, 10'd1,    1'b1},
        '{1'b0, 8'h00, 10'd257,  1'b1},
        '{1'b0, 8'h00, 10'd258,  1'b0},
        '{1'b0, 8'h00, 10'd600,  1'b0},
        '{1'b1, 8'h01, 10'd700,  1'b0},
        '{1'b0, 8'h00, 10'd100,  1'b1},
        '{1'b0, 8'h00, 10'd1023, 1'b0},
        '{1'b0, 8'h00, 10'd0,    1'b1},
        '{1'b0, 8'h00, 10'd5,    1'b1},
        '{1'b0, 8'h00, 10'd6,    1'b0},
        '{1'b1, 8'h00, 10'd300,  1'b0},
        '{1'b0, 8'h00, 10'd0,    1'b1},
        '{1'b0, 8'h00, 10'd1,    1'b1},
        '{1'b0, 8'h00, 10'd2,    1'b0}
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wctl(input logic [7:0] v);
        wr_ctrl = 1'b1; wr_data = v; step();
        wr_ctrl = 1'b0; step();
    endtask

    task automatic wlo(input logic [7:0] v);
        wr_lo = 1'b1; wr_data = v; step();
        wr_lo = 1'b0;
    endtask

    task automatic whi(input logic [7:0] v);
        wr_hi = 1'b1; wr_data = v; step();
        wr_hi = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1; step();
        flag_clr = 1'b0;
    endtask

    task automatic rise(input logic [15:0] t);
        timer_val = t; pin_in = 1'b1; step();
        pin_in = 1'b0; step();
    endtask

    task automatic set_count(input logic [9:0] c);
        timer_val = {8'h00, c[9:2]};
        tmr_fine  = c[1:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        check("R1 ctrl", 32'(ctrl_rd), 32'h0);
        check("R1 data", 32'(data_rd), 32'h0);
        check("R1 pin", {pin_out, pin_drive, irq_flag, tmr_rst_pulse, adc_start_pulse}, 32'h0);

        // R2 register access
        wctl(8'hFF);
        check("R2 ctrl top bits", 32'(ctrl_rd), 32'h3F);
        wctl(8'h00);
        wlo(8'hA5); whi(8'h3C);
        check("R2 data bytes", 32'(data_rd), 32'h3CA5);

        // R4 rising capture
        wctl(8'h05);
        timer_val = 16'h1234; pin_in = 1'b1; step();
        check("R4 rise capture", 32'(data_rd), 32'h1234);
        check("R4 flag", 32'(irq_flag), 32'h1);
        timer_val = 16'h5555; pin_in = 1'b0; step();
        check("R4 fall ignored", 32'(data_rd), 32'h1234);
        clr_flag();
        check("R10 flag cleared", 32'(irq_flag), 32'h0);

        // R4 falling capture
        wctl(8'h04);
        timer_val = 16'h2222; pin_in = 1'b1; step();
        check("R4 rise ignored", 32'(data_rd), 32'h1234);
        timer_val = 16'h3333; pin_in = 1'b0; step();
        check("R4 fall capture", 32'(data_rd), 32'h3333);

        // R5 divide by 4
        wctl(8'h06);
        rise(16'h0101); rise(16'h0102); rise(16'h0103);
        check("R5 div4 before 4th", 32'(data_rd), 32'h3333);
        rise(16'h0104);
        check("R5 div4 4th", 32'(data_rd), 32'h0104);

        // R6 prescale restart on mode change
        rise(16'h0201); rise(16'h0202);
        wctl(8'h07); wctl(8'h06);
        rise(16'h0203); rise(16'h0204); rise(16'h0205);
        check("R6 no early capture", 32'(data_rd), 32'h0104);
        rise(16'h0206);
        check("R6 aligned capture", 32'(data_rd), 32'h0206);

        // R5 divide by 16
        wctl(8'h07);
        for (int i = 1; i <= 15; i++) rise(16'h0300 + 16'(i));
        check("R5 div16 before 16th", 32'(data_rd), 32'h0206);
        rise(16'h0310);
        check("R5 div16 16th", 32'(data_rd), 32'h0310);

        // R3 reserved modes
        wctl(8'h01);
        clr_flag();
        rise(16'h0777);
        check("R3 mode1 no capture", 32'(data_rd), 32'h0310);
        check("R3 mode1 no flag", 32'(irq_flag), 32'h0);
        check("R3 mode1 not driven", {pin_drive, pin_out}, 32'h0);
        wctl(8'h03);
        timer_val = 16'h0310; step(); step();
        check("R3 mode3 no match", 32'(irq_flag), 32'h0);

        // R7 / R9 compare clear-on-match
        timer_val = 16'h0000;
        wlo(8'h00); whi(8'h01);
        wctl(8'h09);
        check("R7 init high", {pin_drive, pin_out}, 32'h3);
        timer_val = 16'h0100; step();
        check("R7 match low", 32'(pin_out), 32'h0);
        check("R7 flag", 32'(irq_flag), 32'h1);
        clr_flag(); step();
        check("R9 held equality", 32'(irq_flag), 32'h0);
        timer_val = 16'h0000; step();
        timer_val = 16'h0100; step();
        check("R9 new equality", 32'(irq_flag), 32'h1);

        // R7 set-on-match
        timer_val = 16'h0000;
        wctl(8'h08);
        check("R7 init low", {pin_drive, pin_out}, 32'h2);
        timer_val = 16'h0100; step();
        check("R7 match high", 32'(pin_out), 32'h1);

        // R7 toggle
        timer_val = 16'h0000;
        wctl(8'h02);
        check("R7 toggle init", 32'(pin_out), 32'h0);
        timer_val = 16'h0100; step();
        check("R7 toggle first", 32'(pin_out), 32'h1);
        timer_val = 16'h0000; step();
        timer_val = 16'h0100; step();
        check("R7 toggle second", 32'(pin_out), 32'h0);

        // R8 event-only
        timer_val = 16'h0000;
        wctl(8'h0A);
        clr_flag();
        timer_val = 16'h0100; step();
        check("R8 event flag", 32'(irq_flag), 32'h1);
        check("R8 event no pin", {pin_drive, pin_out, tmr_rst_pulse, adc_start_pulse}, 32'h0);

        // R10 set wins over clear
        timer_val = 16'h0000; step();
        flag_clr = 1'b1; timer_val = 16'h0100; step();
        flag_clr = 1'b0;
        check("R10 set wins", 32'(irq_flag), 32'h1);

        // R8 special event
        timer_val = 16'h0000;
        wctl(8'h0B);
        timer_val = 16'h0100; step();
        check("R8 special pulses", {tmr_rst_pulse, adc_start_pulse, pin_drive}, 32'h6);
        step();
        check("R8 pulses one cycle", {tmr_rst_pulse, adc_start_pulse}, 32'h0);

        // R3 mode 0000 releases pin
        timer_val = 16'h0000;
        wctl(8'h08);
        timer_val = 16'h0100; step();
        timer_val = 16'h0000;
        wctl(8'h00);
        check("R3 disable releases pin", {pin_drive, pin_out}, 32'h0);

        // R11 / R12 PWM table, duty = {0x40, 2'b10} = 258
        set_count(10'd500);
        wlo(8'h40);
        wctl(8'h2C);
        for (int i = 0; i < NVEC; i++) begin
            set_count(PWM_TAB[i].cnt);
            wr_lo   = PWM_TAB[i].do_wr;
            wr_data = PWM_TAB[i].wr_val;
            step();
            wr_lo = 1'b0;
            if (i == 6) check("R12 mid-period write held", 32'(pin_out), 32'(PWM_TAB[i].exp_pin));
            else        check("R11 pwm vector", 32'(pin_out), 32'(PWM_TAB[i].exp_pin));
        end
        check("R11 pwm drives", 32'(pin_drive), 32'h1);

        // R11 duty zero keeps pin low
        set_count(10'd300);
        wlo(8'h00);
        wctl(8'h0C);
        set_count(10'd0); step();
        check("R11 duty zero at start", 32'(pin_out), 32'h0);
        set_count(10'd1); step();
        check("R11 duty zero later", 32'(pin_out), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule